// File: doc/BRIEF.md
# Post-Reset Configuration Sequencer

This block decides what happens between the end of a fundamental reset and the moment the device core is allowed to run. When reset is released it samples a mode strap and a halt strap. Depending on the mode it either releases the core at once or first loads configuration records from a serial EEPROM. Each record it reads becomes one write on the register-file write port, replacing the default value held there.

The EEPROM is reached through a byte-read handshake that stands in for the SMBus master engine. The image is a list of 4-byte records. Each record holds a 16-bit register address followed by 16-bit data, with the most significant byte first in both fields. A record whose address is all ones ends the image. A reserved mode value, or a read that is not acknowledged, raises an error flag. In both cases the sequence still goes on with whatever defaults remain.

When the halt strap was captured high, the core stays in reset after loading. The management path stays usable during this time. The core is released only when that path writes the control register with its halt bit cleared. A done flag rises one cycle ahead of the core reset release, and both stay high until the next fundamental reset.

Top module: `rstcfg_seq`

## Requirements
- R1: While rst_n is low, and immediately when it goes low, core_rst_n, cfg_done, cfg_err, rd_req and cfg_wr_en are 0. Asserting rst_n mid-sequence restarts the whole sequence from the beginning once it is released.
- R2: mode_strap and halt_strap pass through a two-flop synchronizer and are captured once, at the first rising edge after reset release. Later changes to them have no effect on reads, writes or release.
- R3: With mode 0 and no halt, no EEPROM read is issued. cfg_done is high after the second rising edge following reset release.
- R4: With mode 1, bytes are read from EEPROM byte address 0 upward, one per acknowledged request. rd_req and rd_addr hold steady until rd_ack or rd_nack.
- R5: In each 4-byte record, bytes 0 and 1 form the register address (MSB first) and bytes 2 and 3 form the data (MSB first). Each record produces exactly one cfg_wr_en cycle carrying those values, in image order.
- R6: A record with address 0xFFFF ends the load without a write. No further reads follow it.
- R7: Mode values 2 to 7 are reserved. They cause no reads and no writes, release with the same timing as mode 0, and set cfg_err.
- R8: rd_nack during loading stops the load and sets cfg_err. The partial record is not written, and the sequence continues to the halt check and release.
- R9: If halt_strap was captured as 1, core_rst_n stays 0 after loading until mgmt_wr_en writes address 0x0040 with data bit 0 = 0. Writes to other addresses, or with bit 0 = 1, have no effect. After the clearing write, cfg_done is high following the next rising edge.
- R10: cfg_done rises exactly one cycle before core_rst_n rises. Both then stay high until reset.
- R11: cfg_err, once set, stays set until the next fundamental reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low fundamental reset, asynchronous assert |
| mode_strap | input | 3 | Configuration mode strap |
| halt_strap | input | 1 | Hold core in reset after configuration |
| rd_req | output | 1 | EEPROM byte read request |
| rd_addr | output | 16 | EEPROM byte address of the request |
| rd_ack | input | 1 | Read completed, rd_data valid |
| rd_nack | input | 1 | Read failed (not acknowledged) |
| rd_data | input | 8 | Byte returned by the read |
| mgmt_wr_en | input | 1 | Management-path register write strobe |
| mgmt_wr_addr | input | 16 | Management write address |
| mgmt_wr_data | input | 16 | Management write data |
| cfg_wr_en | output | 1 | Register-file write strobe from EEPROM load |
| cfg_wr_addr | output | 16 | Register address of the write |
| cfg_wr_data | output | 16 | Register data of the write |
| cfg_done | output | 1 | Configuration finished, sticky |
| cfg_err | output | 1 | Reserved mode or read failure, sticky |
| core_rst_n | output | 1 | Core reset release (high = running) |

## Verification
Without loading or halt, cfg_done is due after the second rising edge after reset release and core_rst_n after the third. The bench samples both at the falling edges that follow those rising edges. After a clearing management write, cfg_done is due after the very next rising edge and core_rst_n one edge later, so the bench checks them at the next two falling edges. Loading length depends on the randomized read latency. For that case the bench records the falling-edge cycle index at which each flag first rises and compares the gap to exactly one cycle. Each register write is captured in the cycle it is strobed and compared, in order, with the image the bench built.

// File: rtl/rstcfg_pkg.sv
package rstcfg_pkg;

   typedef enum logic [2:0] {
      ST_CAPTURE,
      ST_LOAD,
      ST_EVAL,
      ST_HALTCHK,
      ST_HALTED,
      ST_DONE,
      ST_RUN
   } seq_state_t;

   localparam int unsigned MODE_PLAIN  = 0;
   localparam int unsigned MODE_EEPROM = 1;
   localparam int unsigned BYTE_W      = 8;

endpackage

// File: rtl/rstcfg_sync.sv
module rstcfg_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rstcfg_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("rstcfg_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) stg[0] <= din;
         end else begin : g_next
            always_ff @(posedge clk) stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/rstcfg_rec_asm.sv
module rstcfg_rec_asm
   import rstcfg_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [ADDR_W-1:0] rec_addr,
   output logic [DATA_W-1:0] rec_data,
   output logic              last_byte
);

   localparam int unsigned REC_W     = ADDR_W + DATA_W;
   localparam int unsigned REC_BYTES = REC_W / BYTE_W;
   localparam int unsigned CNT_W     = (REC_BYTES > 2) ? $clog2(REC_BYTES) : 1;

   generate
      if ((ADDR_W % BYTE_W) != 0 || ADDR_W == 0) begin : g_bad_addr
         $error("rstcfg_rec_asm: ADDR_W must be a nonzero multiple of 8");
      end
      if ((DATA_W % BYTE_W) != 0 || DATA_W == 0) begin : g_bad_data
         $error("rstcfg_rec_asm: DATA_W must be a nonzero multiple of 8");
      end
   endgenerate

   logic [REC_W-1:0] shreg;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt   <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (byte_vld) begin
         shreg <= {shreg[REC_W-BYTE_W-1:0], byte_in};
         cnt   <= cnt + CNT_W'(1);
      end
   end

   assign last_byte = (cnt == CNT_W'(REC_BYTES - 1));
   assign rec_addr  = shreg[REC_W-1 -: ADDR_W];
   assign rec_data  = shreg[DATA_W-1:0];

endmodule

// File: rtl/rstcfg_ctrl.sv
module rstcfg_ctrl
   import rstcfg_pkg::*;
#(
   parameter int unsigned MODE_W    = 3,
   parameter int unsigned EE_ADDR_W = 16,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned CTRL_ADDR = 'h40
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [MODE_W-1:0]    mode_s,
   input  logic                 halt_s,
   input  logic                 rd_ack,
   input  logic                 rd_nack,
   input  logic                 last_byte,
   input  logic [ADDR_W-1:0]    rec_addr,
   input  logic                 mgmt_wr_en,
   input  logic [ADDR_W-1:0]    mgmt_wr_addr,
   input  logic                 mgmt_halt_bit,
   output logic                 rd_req,
   output logic [EE_ADDR_W-1:0] rd_addr,
   output logic                 byte_vld,
   output logic                 rec_clr,
   output logic                 cfg_wr_en,
   output logic                 cfg_done,
   output logic                 cfg_err,
   output logic                 core_rst_n
);

   localparam logic [ADDR_W-1:0] END_ADDR = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(CTRL_ADDR);

   seq_state_t           state, state_nx;
   logic                 halt_q;
   logic                 err_q;
   logic [EE_ADDR_W-1:0] ee_ptr;
   logic                 halt_clear;
   logic                 mode_rsvd;
   logic                 mode_load;
   logic                 end_rec;

   assign halt_clear = mgmt_wr_en && (mgmt_wr_addr == CTRL_A) && !mgmt_halt_bit;
   assign mode_rsvd  = (mode_s > MODE_W'(MODE_EEPROM));
   assign mode_load  = (mode_s == MODE_W'(MODE_EEPROM));
   assign end_rec    = (rec_addr == END_ADDR);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_CAPTURE: state_nx = mode_load ? ST_LOAD : ST_HALTCHK;
         ST_LOAD: begin
            if (rd_nack)                  state_nx = ST_HALTCHK;
            else if (rd_ack && last_byte) state_nx = ST_EVAL;
         end
         ST_EVAL:    state_nx = end_rec ? ST_HALTCHK : ST_LOAD;
         ST_HALTCHK: state_nx = (halt_q && !halt_clear) ? ST_HALTED : ST_DONE;
         ST_HALTED:  if (!halt_q || halt_clear) state_nx = ST_DONE;
         ST_DONE:    state_nx = ST_RUN;
         ST_RUN:     state_nx = ST_RUN;
         default:    state_nx = ST_CAPTURE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_CAPTURE;
         halt_q <= 1'b0;
         err_q  <= 1'b0;
         ee_ptr <= '0;
      end else begin
         state <= state_nx;
         if (state == ST_CAPTURE) begin
            halt_q <= halt_s;
         end else if (halt_clear) begin
            halt_q <= 1'b0;
         end
         if ((state == ST_CAPTURE && mode_rsvd) || (state == ST_LOAD && rd_nack)) begin
            err_q <= 1'b1;
         end
         if (byte_vld) begin
            ee_ptr <= ee_ptr + EE_ADDR_W'(1);
         end
      end
   end

   assign rd_req     = (state == ST_LOAD);
   assign rd_addr    = ee_ptr;
   assign byte_vld   = (state == ST_LOAD) && rd_ack && !rd_nack;
   assign rec_clr    = (state == ST_EVAL);
   assign cfg_wr_en  = (state == ST_EVAL) && !end_rec;
   assign cfg_done   = (state == ST_DONE) || (state == ST_RUN);
   assign core_rst_n = (state == ST_RUN);
   assign cfg_err    = err_q;

endmodule

// File: rtl/rstcfg_seq.sv
module rstcfg_seq
   import rstcfg_pkg::*;
#(
   parameter int unsigned MODE_W      = 3,
   parameter int unsigned EE_ADDR_W   = 16,
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CTRL_ADDR   = 'h40,
   parameter int unsigned HALT_BIT    = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [MODE_W-1:0]    mode_strap,
   input  logic                 halt_strap,
   output logic                 rd_req,
   output logic [EE_ADDR_W-1:0] rd_addr,
   input  logic                 rd_ack,
   input  logic                 rd_nack,
   input  logic [7:0]           rd_data,
   input  logic                 mgmt_wr_en,
   input  logic [ADDR_W-1:0]    mgmt_wr_addr,
   input  logic [DATA_W-1:0]    mgmt_wr_data,
   output logic                 cfg_wr_en,
   output logic [ADDR_W-1:0]    cfg_wr_addr,
   output logic [DATA_W-1:0]    cfg_wr_data,
   output logic                 cfg_done,
   output logic                 cfg_err,
   output logic                 core_rst_n
);

   localparam int unsigned STRAP_W = MODE_W + 1;

   generate
      if (HALT_BIT >= DATA_W) begin : g_bad_halt_bit
         $error("rstcfg_seq: HALT_BIT outside DATA_W");
      end
      if (MODE_W < 1) begin : g_bad_mode_w
         $error("rstcfg_seq: MODE_W must be at least 1");
      end
   endgenerate

   logic [STRAP_W-1:0] strap_s;
   logic               last_byte;
   logic               byte_vld;
   logic               rec_clr;
   logic               unused_mgmt;

   assign unused_mgmt = ^mgmt_wr_data;

   rstcfg_sync #(
      .WIDTH  (STRAP_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .din  ({halt_strap, mode_strap}),
      .dout (strap_s)
   );

   rstcfg_rec_asm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_rec (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (rec_clr),
      .byte_vld  (byte_vld),
      .byte_in   (rd_data),
      .rec_addr  (cfg_wr_addr),
      .rec_data  (cfg_wr_data),
      .last_byte (last_byte)
   );

   rstcfg_ctrl #(
      .MODE_W    (MODE_W),
      .EE_ADDR_W (EE_ADDR_W),
      .ADDR_W    (ADDR_W),
      .CTRL_ADDR (CTRL_ADDR)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_s        (strap_s[MODE_W-1:0]),
      .halt_s        (strap_s[MODE_W]),
      .rd_ack        (rd_ack),
      .rd_nack       (rd_nack),
      .last_byte     (last_byte),
      .rec_addr      (cfg_wr_addr),
      .mgmt_wr_en    (mgmt_wr_en),
      .mgmt_wr_addr  (mgmt_wr_addr),
      .mgmt_halt_bit (mgmt_wr_data[HALT_BIT]),
      .rd_req        (rd_req),
      .rd_addr       (rd_addr),
      .byte_vld      (byte_vld),
      .rec_clr       (rec_clr),
      .cfg_wr_en     (cfg_wr_en),
      .cfg_done      (cfg_done),
      .cfg_err       (cfg_err),
      .core_rst_n    (core_rst_n)
   );

endmodule

// File: rtl/rstcfg_seq_chk.sv
module rstcfg_seq_chk #(
   parameter int unsigned EE_ADDR_W = 16,
   parameter int unsigned ADDR_W    = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 rd_req,
   input logic [EE_ADDR_W-1:0] rd_addr,
   input logic                 rd_ack,
   input logic                 rd_nack,
   input logic                 cfg_wr_en,
   input logic [ADDR_W-1:0]    cfg_wr_addr,
   input logic                 cfg_done,
   input logic                 cfg_err,
   input logic                 core_rst_n
);

   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack && !rd_nack) |=> (rd_req && $stable(rd_addr)));

   assert_no_end_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_en |-> (cfg_wr_addr != {ADDR_W{1'b1}}));

   assert_quiet_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |-> (!rd_req && !cfg_wr_en));

   assert_done_leads_core_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_rst_n) |-> $past(cfg_done));

   assert_core_implies_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_n |-> cfg_done);

   assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> cfg_done);

   assert_core_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_n |=> core_rst_n);

   assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);

endmodule

bind rstcfg_seq rstcfg_seq_chk #(
   .EE_ADDR_W (EE_ADDR_W),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_req      (rd_req),
   .rd_addr     (rd_addr),
   .rd_ack      (rd_ack),
   .rd_nack     (rd_nack),
   .cfg_wr_en   (cfg_wr_en),
   .cfg_wr_addr (cfg_wr_addr),
   .cfg_done    (cfg_done),
   .cfg_err     (cfg_err),
   .core_rst_n  (core_rst_n)
);

// File: tb/rstcfg_seq_tb.sv
module rstcfg_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_strap = 3'd0;
   logic        halt_strap = 1'b0;
   logic        rd_req;
   logic [15:0] rd_addr;
   logic        rd_ack = 1'b0;
   logic        rd_nack = 1'b0;
   logic [7:0]  rd_data = 8'h00;
   logic        mgmt_wr_en = 1'b0;
   logic [15:0] mgmt_wr_addr = 16'h0;
   logic [15:0] mgmt_wr_data = 16'h0;
   logic        cfg_wr_en;
   logic [15:0] cfg_wr_addr;
   logic [15:0] cfg_wr_data;
   logic        cfg_done;
   logic        cfg_err;
   logic        core_rst_n;

   always #10 clk = ~clk;

   rstcfg_seq u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_strap   (mode_strap),
      .halt_strap   (halt_strap),
      .rd_req       (rd_req),
      .rd_addr      (rd_addr),
      .rd_ack       (rd_ack),
      .rd_nack      (rd_nack),
      .rd_data      (rd_data),
      .mgmt_wr_en   (mgmt_wr_en),
      .mgmt_wr_addr (mgmt_wr_addr),
      .mgmt_wr_data (mgmt_wr_data),
      .cfg_wr_en    (cfg_wr_en),
      .cfg_wr_addr  (cfg_wr_addr),
      .cfg_wr_data  (cfg_wr_data),
      .cfg_done     (cfg_done),
      .cfg_err      (cfg_err),
      .core_rst_n   (core_rst_n)
   );

   int n_chk = 0;
   int n_err = 0;

   logic [7:0]  mem [0:255];
   logic [15:0] exp_a [0:15];
   logic [15:0] exp_d [0:15];
   logic [15:0] got_a [0:31];
   logic [15:0] got_d [0:31];
   int nw = 0;
   int reads = 0;
   int nack_at = -1;
   int cyc = 0;
   int done_cyc = -1;
   int core_cyc = -1;

   task automatic chk(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] rnd_addr();
      return 16'($urandom_range(0, 16'hFFFE));
   endfunction

   // EEPROM read model with random latency
   initial begin
      int lat = 0;
      forever begin
         @(negedge clk);
         if (rd_ack || rd_nack) begin
            rd_ack  = 1'b0;
            rd_nack = 1'b0;
         end else if (rd_req && rst_n) begin
            if (lat > 0) lat--;
            else begin
               if (int'(rd_addr) == nack_at) rd_nack = 1'b1;
               else begin
                  rd_ack  = 1'b1;
                  rd_data = mem[rd_addr[7:0]];
               end
               reads++;
               lat = $urandom_range(0, 2);
            end
         end
      end
   end

   // output monitors
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (cfg_wr_en && nw < 32) begin
            got_a[nw] = cfg_wr_addr;
            got_d[nw] = cfg_wr_data;
            nw++;
         end
         if (cfg_done && done_cyc < 0) done_cyc = cyc;
         if (core_rst_n && core_cyc < 0) core_cyc = cyc;
      end
   end

   task automatic build_image(int nrec);
      for (int r = 0; r < nrec; r++) begin
         exp_a[r] = rnd_addr();
         exp_d[r] = 16'($urandom);
         mem[4*r]   = exp_a[r][15:8];
         mem[4*r+1] = exp_a[r][7:0];
         mem[4*r+2] = exp_d[r][15:8];
         mem[4*r+3] = exp_d[r][7:0];
      end
      for (int b = 0; b < 4; b++) mem[4*nrec+b] = 8'hFF;
   endtask

   task automatic do_reset(logic [2:0] m, logic h);
      @(negedge clk);
      rst_n = 1'b0;
      mode_strap = m;
      halt_strap = h;
      mgmt_wr_en = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1", "core_rst_n in reset", core_rst_n, 0);
      chk("R1", "cfg_done in reset", cfg_done, 0);
      chk("R1", "cfg_err in reset", cfg_err, 0);
      chk("R1", "rd_req in reset", rd_req, 0);
      nw = 0; reads = 0; done_cyc = -1; core_cyc = -1;
      rst_n = 1'b1;
   endtask

   task automatic wait_done(string req);
      int n = 0;
      while (!core_rst_n && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk(req, "release reached", core_rst_n, 1);
      chk("R10", "done-to-core gap", core_cyc - done_cyc, 1);
   endtask

   task automatic mgmt_write(logic [15:0] a, logic [15:0] d);
      mgmt_wr_en = 1'b1;
      mgmt_wr_addr = a;
      mgmt_wr_data = d;
      @(negedge clk);
      mgmt_wr_en = 1'b0;
   endtask

   task automatic check_writes(string req, int nrec);
      chk(req, "write count", nw, nrec);
      for (int r = 0; r < nrec && r < nw; r++) begin
         chk(req, "write addr", got_a[r], exp_a[r]);
         chk(req, "write data", got_d[r], exp_d[r]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog R10: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4321));
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;

      // mode 0, exact release timing; strap changes after capture ignored
      do_reset(3'd0, 1'b0);
      @(negedge clk);
      chk("R3", "done after first edge", cfg_done, 0);
      mode_strap = 3'd1;
      halt_strap = 1'b1;
      @(negedge clk);
      chk("R3", "done after second edge", cfg_done, 1);
      chk("R10", "core before its edge", core_rst_n, 0);
      @(negedge clk);
      chk("R10", "core after third edge", core_rst_n, 1);
      repeat (10) @(negedge clk);
      chk("R2", "no reads after strap change", reads, 0);
      chk("R2", "core stays running", core_rst_n, 1);
      chk("R3", "no writes in mode 0", nw, 0);
      chk("R11", "no error in mode 0", cfg_err, 0);

      // reserved modes
      for (int m = 2; m < 8; m += 3) begin
         do_reset(3'(m), 1'b0);
         repeat (2) @(negedge clk);
         chk("R7", "reserved done timing", cfg_done, 1);
         @(negedge clk);
         chk("R7", "reserved core timing", core_rst_n, 1);
         chk("R7", "reserved error flag", cfg_err, 1);
         chk("R7", "reserved no reads", reads, 0);
         repeat (5) @(negedge clk);
         chk("R11", "error sticky", cfg_err, 1);
      end

      // randomized EEPROM images
      for (int it = 0; it < 6; it++) begin
         int nrec = (it == 0) ? 0 : $urandom_range(1, 9);
         nack_at = -1;
         build_image(nrec);
         do_reset(3'd1, 1'b0);
         wait_done("R5");
         check_writes("R5", nrec);
         chk("R6", "reads up to end record", reads, 4 * (nrec + 1));
         chk("R4", "no error on clean load", cfg_err, 0);
      end

      // read failure mid record 2
      build_image(5);
      nack_at = 9;
      do_reset(3'd1, 1'b0);
      wait_done("R8");
      check_writes("R8", 2);
      chk("R8", "error after nack", cfg_err, 1);
      chk("R8", "no reads past nack", reads, 10);
      nack_at = -1;

      // halt with mode 0
      do_reset(3'd0, 1'b1);
      repeat (40) @(negedge clk);
      chk("R9", "halted core", core_rst_n, 0);
      chk("R9", "halted done", cfg_done, 0);
      mgmt_write(16'h0041, 16'h0000);
      mgmt_write(16'h0040, 16'h0001);
      repeat (5) @(negedge clk);
      chk("R9", "ignored writes keep halt", core_rst_n, 0);
      chk("R9", "ignored writes keep done low", cfg_done, 0);
      mgmt_write(16'h0040, 16'hFFFE);
      chk("R9", "done after clearing write", cfg_done, 1);
      chk("R10", "core one cycle later", core_rst_n, 0);
      @(negedge clk);
      chk("R10", "core released", core_rst_n, 1);

      // halt with EEPROM load
      build_image(3);
      do_reset(3'd1, 1'b1);
      repeat (80) @(negedge clk);
      check_writes("R9", 3);
      chk("R9", "halted after load", core_rst_n, 0);
      mgmt_write(16'h0040, 16'h0000);
      @(negedge clk);
      chk("R9", "released after clear", core_rst_n, 1);

      // reset in the middle of a load restarts the sequence
      build_image(6);
      do_reset(3'd1, 1'b0);
      while (nw < 2) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1", "async reset drops request", rd_req, 0);
      chk("R1", "async reset drops done", cfg_done, 0);
      do_reset(3'd1, 1'b0);
      wait_done("R1");
      check_writes("R1", 6);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule